// File: doc/BRIEF.md
# SWD Transfer Sequencer

This block runs one complete SWD read or write transfer by handing a sequence of commands to a serial bit engine. Each command names a bit count (stored as count minus one), whether the data line is driven, and whether bits are shifted out or sampled in. Write commands carry their payload in the same beat. Every read command produces exactly one result word from the engine.

A transfer begins with a one-cycle `start` pulse that carries the request fields, the write word, the turnaround length, the number of trailing idle clocks and the data-phase option. The sequencer builds and sends the request packet. It reads the turnaround and the acknowledge in a single read and then branches on the acknowledge. An OK leads to the data phase and the idle clocks. WAIT or FAULT leads to an optional dummy data phase. Any other code leads to a back-off read. When the transfer ends, the sequencer raises `done` for one cycle and holds the acknowledge, the read word and a parity-error flag until the next start.

Top module: `swd_xfer_seq`

## Requirements
- R1: The first command of every transfer is a driven 8-bit write (`cmd_cnt_m1`=7, `cmd_oe`=1, `cmd_read`=0). Its payload bits [7:0] are, from bit 0 upward: 1, APnDP, RnW, A[2], A[3], the even parity of those four fields, 0, 1. Here A[2]=`req_addr[0]` and A[3]=`req_addr[1]`.
- R2: The second command is a released read of turnaround+3 bits. Turnaround is `turn_m1`+1 clocks. The acknowledge is bits [turnaround+2:turnaround] of its result, and `ack` presents it with OK=3'b001, WAIT=3'b010, FAULT=3'b100.
- R3: For an OK read, the sequencer issues a released 33-bit read (`cmd_cnt_m1`=32) and then a released non-reading command of turnaround clocks. `rdata` shows result bits [31:0].
- R4: For an OK write, the sequencer issues the released turnaround command first. It then issues a driven 33-bit write whose payload is {XOR of `wdata`, `wdata`}.
- R5: After an OK transfer, `idle_cycles` clocks are sent as driven zero writes in chunks of at most 256 bits, with full chunks first. No such command is sent when the count is 0.
- R6: On WAIT or FAULT, the sequencer first issues a released 33-bit dummy read if `data_phase` is set and the request is a read. It then issues the released turnaround command. Last, if `data_phase` is set and the request is a write, it issues a driven 32-bit zero write.
- R7: On any other acknowledge, the sequencer issues one released read of turnaround+33 bits and then ends the transfer.
- R8: `done` is high for exactly one cycle. It follows the handshake of the last command and the result of every read. No command is offered while a read result is pending or while idle, and `start` has no effect while `busy`.
- R9: While `cmd_valid` is high and `cmd_ready` is low, every command field holds steady. `cmd_wdata` is zero on every read and every released command.
- R10: `parity_err` is high after an OK read whose result bit 32 differs from the XOR of bits [31:0]. It is low after any other transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, taken when idle |
| req_apndp | input | 1 | Access-port (1) or debug-port (0) select |
| req_rnw | input | 1 | Read (1) or write (0) |
| req_addr | input | 2 | Register address bits A[3:2] |
| wdata | input | 32 | Word to write |
| turn_m1 | input | 2 | Turnaround length minus one |
| idle_cycles | input | IDLE_W | Idle clocks after an OK transfer |
| data_phase | input | 1 | Run a dummy data phase on WAIT/FAULT |
| cmd_valid | output | 1 | Command offered to the bit engine |
| cmd_ready | input | 1 | Engine accepts the command |
| cmd_read | output | 1 | Command samples bits and returns a result |
| cmd_oe | output | 1 | Data line driven during the command |
| cmd_cnt_m1 | output | CNT_W | Bit count minus one |
| cmd_wdata | output | 33 | Payload, bit 0 sent first |
| rsp_valid | input | 1 | Read result available |
| rsp_data | input | 33 | Read result, first bit in bit 0 |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| ack | output | 3 | Captured acknowledge |
| rdata | output | 32 | Captured read word |
| parity_err | output | 1 | Read-word parity mismatch |

## Verification
On every cycle, the assertions check the command handshake rules. These are: fields stay stable under back-pressure, reads release the line, and zero payloads appear where no data is sent. They also check that no command is offered while a read result is pending or when idle, that a start launches the driven 8-bit request, that `done` is a single pulse, and that a parity error is flagged only with an OK. The exact order and contents of each command list can only be shown by the bench's scenarios, which compare it entry by entry against a list built from the requirements. This covers the branch on each acknowledge code, how the idle clocks split at the 256 boundary, and the shift that extracts the acknowledge for each turnaround length. The bench scenarios also cover the parity result and the rejection of a second start.

// File: rtl/swd_seq_pkg.sv
package swd_seq_pkg;

  localparam int WORD_W = 32;
  localparam int PKT_W  = WORD_W + 1;
  localparam int TURN_W = 2;
  localparam int ACK_W  = 3;
  localparam int REQ_W  = 8;

  localparam logic [ACK_W-1:0] ACK_OK    = 3'b001;
  localparam logic [ACK_W-1:0] ACK_WAIT  = 3'b010;
  localparam logic [ACK_W-1:0] ACK_FAULT = 3'b100;

  typedef enum logic [3:0] {
    ST_IDLE, ST_REQ, ST_ACK, ST_ACK_WT, ST_RDAT, ST_RDAT_WT, ST_TURN,
    ST_WDAT, ST_IDLECLK, ST_DRD, ST_DRD_WT, ST_DWR, ST_BOFF, ST_BOFF_WT,
    ST_DONE
  } seq_state_e;

  // Request packet, bit 0 leaves the pin first.
  function automatic logic [REQ_W-1:0] build_request(logic apndp, logic rnw,
                                                     logic [1:0] addr);
    logic par;
    par = apndp ^ rnw ^ addr[0] ^ addr[1];
    return {1'b1, 1'b0, par, addr[1], addr[0], rnw, apndp, 1'b1};
  endfunction

  function automatic logic word_parity(logic [WORD_W-1:0] w);
    return ^w;
  endfunction

  // Drop the turnaround bits that lead the acknowledge.
  function automatic logic [ACK_W-1:0] ack_from_rsp(logic [PKT_W-1:0] rsp,
                                                    logic [TURN_W-1:0] turn_m1);
    logic [TURN_W:0]  shift;
    logic [PKT_W-1:0] moved;
    shift = {1'b0, turn_m1} + 1'b1;
    moved = rsp >> shift;
    return moved[ACK_W-1:0];
  endfunction

endpackage

// File: rtl/swd_req_encoder.sv
module swd_req_encoder
  import swd_seq_pkg::*;
(
  input  logic             apndp,
  input  logic             rnw,
  input  logic [1:0]       addr,
  output logic [REQ_W-1:0] req_byte
);
  assign req_byte = build_request(apndp, rnw, addr);
endmodule

// File: rtl/swd_idle_chunker.sv
module swd_idle_chunker #(
  parameter int CNT_W  = 8,
  parameter int IDLE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [IDLE_W-1:0] load_cnt,
  input  logic              take,
  output logic [CNT_W-1:0]  chunk_m1,
  output logic              last,
  output logic              none
);
  localparam logic [IDLE_W-1:0] CHUNK = IDLE_W'(2 ** CNT_W);

  logic [IDLE_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    remain <= '0;
    else if (load) remain <= load_cnt;
    else if (take) remain <= last ? '0 : remain - CHUNK;
  end

  assign last     = (remain <= CHUNK);
  assign none     = (remain == '0);
  assign chunk_m1 = last ? CNT_W'(remain - IDLE_W'(1)) : {CNT_W{1'b1}};
endmodule

// File: rtl/swd_rsp_capture.sv
module swd_rsp_capture
  import swd_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              ack_take,
  input  logic              data_take,
  input  logic [TURN_W-1:0] turn_m1,
  input  logic [PKT_W-1:0]  rsp_data,
  output logic [ACK_W-1:0]  ack,
  output logic [WORD_W-1:0] rdata,
  output logic              perr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack   <= '0;
      rdata <= '0;
      perr  <= 1'b0;
    end else if (clear) begin
      ack   <= '0;
      rdata <= '0;
      perr  <= 1'b0;
    end else begin
      if (ack_take) ack <= ack_from_rsp(rsp_data, turn_m1);
      if (data_take) begin
        rdata <= rsp_data[WORD_W-1:0];
        perr  <= word_parity(rsp_data[WORD_W-1:0]) != rsp_data[WORD_W];
      end
    end
  end
endmodule

// File: rtl/swd_xfer_seq.sv
module swd_xfer_seq
  import swd_seq_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int IDLE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              req_apndp,
  input  logic              req_rnw,
  input  logic [1:0]        req_addr,
  input  logic [31:0]       wdata,
  input  logic [1:0]        turn_m1,
  input  logic [IDLE_W-1:0] idle_cycles,
  input  logic              data_phase,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_read,
  output logic              cmd_oe,
  output logic [CNT_W-1:0]  cmd_cnt_m1,
  output logic [32:0]       cmd_wdata,
  input  logic              rsp_valid,
  input  logic [32:0]       rsp_data,
  output logic              busy,
  output logic              done,
  output logic [2:0]        ack,
  output logic [31:0]       rdata,
  output logic              parity_err
);
  localparam logic [CNT_W-1:0] M1_REQ   = CNT_W'(REQ_W - 1);
  localparam logic [CNT_W-1:0] M1_PKT   = CNT_W'(PKT_W - 1);
  localparam logic [CNT_W-1:0] M1_WORD  = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] ACK_ADD  = CNT_W'(ACK_W);
  localparam logic [CNT_W-1:0] BOFF_ADD = CNT_W'(PKT_W);

  seq_state_e st, st_nx;

  logic              lat_apndp, lat_rnw, lat_dp;
  logic [1:0]        lat_addr;
  logic [TURN_W-1:0] lat_turn;
  logic [WORD_W-1:0] lat_wdata;

  // Named events used by the logic and by the checker.
  logic xfer_start, cmd_fire, rd_wait, rsp_take, ack_take, data_take, chunk_take;
  logic [ACK_W-1:0] fresh_ack;
  logic [REQ_W-1:0] req_byte;
  logic [CNT_W-1:0] chunk_m1, turn_ext;
  logic             chunk_last, idle_none;

  assign xfer_start = start && (st == ST_IDLE);
  assign cmd_fire   = cmd_valid && cmd_ready;
  assign rd_wait    = (st == ST_ACK_WT) || (st == ST_RDAT_WT) ||
                      (st == ST_DRD_WT) || (st == ST_BOFF_WT);
  assign rsp_take   = rd_wait && rsp_valid;
  assign ack_take   = rsp_take && (st == ST_ACK_WT);
  assign data_take  = rsp_take && (st == ST_RDAT_WT);
  assign chunk_take = cmd_fire && (st == ST_IDLECLK);
  assign fresh_ack  = ack_from_rsp(rsp_data, lat_turn);
  assign turn_ext   = CNT_W'(lat_turn);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_apndp <= 1'b0;
      lat_rnw   <= 1'b0;
      lat_addr  <= '0;
      lat_turn  <= '0;
      lat_dp    <= 1'b0;
      lat_wdata <= '0;
    end else if (xfer_start) begin
      lat_apndp <= req_apndp;
      lat_rnw   <= req_rnw;
      lat_addr  <= req_addr;
      lat_turn  <= turn_m1;
      lat_dp    <= data_phase;
      lat_wdata <= wdata;
    end
  end

  swd_req_encoder u_req (
    .apndp    (lat_apndp),
    .rnw      (lat_rnw),
    .addr     (lat_addr),
    .req_byte (req_byte)
  );

  swd_idle_chunker #(.CNT_W(CNT_W), .IDLE_W(IDLE_W)) u_idle (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (xfer_start),
    .load_cnt (idle_cycles),
    .take     (chunk_take),
    .chunk_m1 (chunk_m1),
    .last     (chunk_last),
    .none     (idle_none)
  );

  swd_rsp_capture u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (xfer_start),
    .ack_take  (ack_take),
    .data_take (data_take),
    .turn_m1   (lat_turn),
    .rsp_data  (rsp_data),
    .ack       (ack),
    .rdata     (rdata),
    .perr      (parity_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE:    if (xfer_start) st_nx = ST_REQ;
      ST_REQ:     if (cmd_fire) st_nx = ST_ACK;
      ST_ACK:     if (cmd_fire) st_nx = ST_ACK_WT;
      ST_ACK_WT:
        if (rsp_valid) begin
          if (fresh_ack == ACK_OK)
            st_nx = lat_rnw ? ST_RDAT : ST_TURN;
          else if (fresh_ack == ACK_WAIT || fresh_ack == ACK_FAULT)
            st_nx = (lat_dp && lat_rnw) ? ST_DRD : ST_TURN;
          else
            st_nx = ST_BOFF;
        end
      ST_RDAT:    if (cmd_fire) st_nx = ST_RDAT_WT;
      ST_RDAT_WT: if (rsp_valid) st_nx = ST_TURN;
      ST_TURN:
        if (cmd_fire) begin
          if (ack == ACK_OK)
            st_nx = !lat_rnw ? ST_WDAT : (idle_none ? ST_DONE : ST_IDLECLK);
          else
            st_nx = (lat_dp && !lat_rnw) ? ST_DWR : ST_DONE;
        end
      ST_WDAT:    if (cmd_fire) st_nx = idle_none ? ST_DONE : ST_IDLECLK;
      ST_IDLECLK: if (cmd_fire && chunk_last) st_nx = ST_DONE;
      ST_DRD:     if (cmd_fire) st_nx = ST_DRD_WT;
      ST_DRD_WT:  if (rsp_valid) st_nx = ST_TURN;
      ST_DWR:     if (cmd_fire) st_nx = ST_DONE;
      ST_BOFF:    if (cmd_fire) st_nx = ST_BOFF_WT;
      ST_BOFF_WT: if (rsp_valid) st_nx = ST_DONE;
      ST_DONE:    st_nx = ST_IDLE;
      default:    st_nx = ST_IDLE;
    endcase
  end

  always_comb begin
    cmd_valid  = 1'b1;
    cmd_read   = 1'b0;
    cmd_oe     = 1'b0;
    cmd_cnt_m1 = '0;
    cmd_wdata  = '0;
    unique case (st)
      ST_REQ: begin
        cmd_oe     = 1'b1;
        cmd_cnt_m1 = M1_REQ;
        cmd_wdata  = PKT_W'(req_byte);
      end
      ST_ACK: begin
        cmd_read   = 1'b1;
        cmd_cnt_m1 = turn_ext + ACK_ADD;
      end
      ST_RDAT, ST_DRD: begin
        cmd_read   = 1'b1;
        cmd_cnt_m1 = M1_PKT;
      end
      ST_TURN: cmd_cnt_m1 = turn_ext;
      ST_WDAT: begin
        cmd_oe     = 1'b1;
        cmd_cnt_m1 = M1_PKT;
        cmd_wdata  = {word_parity(lat_wdata), lat_wdata};
      end
      ST_IDLECLK: begin
        cmd_oe     = 1'b1;
        cmd_cnt_m1 = chunk_m1;
      end
      ST_DWR: begin
        cmd_oe     = 1'b1;
        cmd_cnt_m1 = M1_WORD;
      end
      ST_BOFF: begin
        cmd_read   = 1'b1;
        cmd_cnt_m1 = turn_ext + BOFF_ADD;
      end
      default: cmd_valid = 1'b0;
    endcase
  end

  assign busy = (st != ST_IDLE);
  assign done = (st == ST_DONE);

endmodule

// File: rtl/swd_xfer_seq_chk.sv
module swd_xfer_seq_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic             cmd_read,
  input logic             cmd_oe,
  input logic [CNT_W-1:0] cmd_cnt_m1,
  input logic [32:0]      cmd_wdata,
  input logic [2:0]       ack,
  input logic             parity_err,
  input logic             xfer_start,
  input logic             rd_wait
);
  AST_REQ_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> busy && cmd_valid && !cmd_read && cmd_oe && cmd_cnt_m1 == CNT_W'(7)); // R1

  AST_READ_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_read |-> !cmd_oe); // R2

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cmd_valid); // R8

  AST_HOLD_FOR_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_wait |-> !cmd_valid); // R8

  AST_CMD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=>
      cmd_valid && $stable(cmd_read) && $stable(cmd_oe) &&
      $stable(cmd_cnt_m1) && $stable(cmd_wdata)); // R9

  AST_ZERO_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_read || !cmd_oe) |-> cmd_wdata == '0); // R9

  AST_PERR_WITH_OK: assert property (@(posedge clk) disable iff (!rst_n)
    parity_err |-> ack == 3'b001); // R10
endmodule

bind swd_xfer_seq swd_xfer_seq_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/test_swd_xfer_seq.sv
module test_swd_xfer_seq;
  localparam int CNT_W  = 8;
  localparam int IDLE_W = 16;
  localparam int EW     = 2 + CNT_W + 33;
  localparam int NV     = 10;

  // {apndp, rnw, addr[1:0], turn_m1[1:0], dp, ack[2:0], badpar, idle[15:0], data[31:0]}
  localparam logic [58:0] VECS [0:NV-1] = '{
    {1'b0, 1'b1, 2'd1, 2'd0, 1'b0, 3'd1, 1'b0, 16'd256, 32'hA5A50F0F},
    {1'b1, 1'b1, 2'd3, 2'd1, 1'b0, 3'd1, 1'b1, 16'd8,   32'h12345678},
    {1'b0, 1'b0, 2'd2, 2'd0, 1'b0, 3'd1, 1'b0, 16'd300, 32'hDEADBEEF},
    {1'b1, 1'b0, 2'd0, 2'd3, 1'b1, 3'd1, 1'b0, 16'd512, 32'h00000001},
    {1'b0, 1'b1, 2'd1, 2'd2, 1'b1, 3'd2, 1'b0, 16'd5,   32'hFFFF0000},
    {1'b1, 1'b0, 2'd2, 2'd0, 1'b1, 3'd4, 1'b0, 16'd5,   32'h0BADF00D},
    {1'b0, 1'b1, 2'd0, 2'd1, 1'b0, 3'd2, 1'b0, 16'd0,   32'h11111111},
    {1'b1, 1'b1, 2'd3, 2'd1, 1'b1, 3'd7, 1'b0, 16'd9,   32'h22222222},
    {1'b0, 1'b0, 2'd1, 2'd0, 1'b0, 3'd0, 1'b0, 16'd9,   32'h33333333},
    {1'b0, 1'b0, 2'd3, 2'd2, 1'b0, 3'd1, 1'b0, 16'd0,   32'h80000000}
  };

  logic              clk, rst_n, start, req_apndp, req_rnw, data_phase;
  logic [1:0]        req_addr, turn_m1;
  logic [31:0]       wdata;
  logic [IDLE_W-1:0] idle_cycles;
  logic              cmd_valid, cmd_ready, cmd_read, cmd_oe;
  logic [CNT_W-1:0]  cmd_cnt_m1;
  logic [32:0]       cmd_wdata;
  logic              rsp_valid;
  logic [32:0]       rsp_data;
  logic              busy, done, parity_err;
  logic [2:0]        ack;
  logic [31:0]       rdata;

  swd_xfer_seq #(.CNT_W(CNT_W), .IDLE_W(IDLE_W)) i_swd_xfer_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .req_apndp(req_apndp),
    .req_rnw(req_rnw), .req_addr(req_addr), .wdata(wdata), .turn_m1(turn_m1),
    .idle_cycles(idle_cycles), .data_phase(data_phase), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_read(cmd_read), .cmd_oe(cmd_oe),
    .cmd_cnt_m1(cmd_cnt_m1), .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .busy(busy), .done(done), .ack(ack), .rdata(rdata),
    .parity_err(parity_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  logic [EW-1:0] log_q [0:15];
  int            log_n;
  logic [EW-1:0] exp_q [0:15];
  string         exp_tag [0:15];
  int            exp_n;

  logic [58:0] cur;
  int          rd_idx, pend_cnt, stall_q;
  logic [32:0] pend_data;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Engine results: acknowledge behind turnaround ones, then data, then junk.
  function automatic logic [32:0] resp_for(int idx);
    int t;
    logic [32:0] r;
    t = int'(cur[54:53]) + 1;
    if (idx == 0) begin
      r = (33'(cur[51:49]) << t) | ((33'd1 << t) - 33'd1);
    end else if (idx == 1 && cur[51:49] == 3'd1 && cur[57]) begin
      r = {(^cur[31:0]) ^ cur[48], cur[31:0]};
    end else begin
      r = '1;
    end
    return r;
  endfunction

  // Bit engine model: stalls one cycle in three, answers reads two cycles later.
  initial begin
    cmd_ready = 1'b0; rsp_valid = 1'b0; rsp_data = '0;
    pend_cnt = 0; stall_q = 0; log_n = 0; rd_idx = 0;
    forever begin
      @(negedge clk);
      rsp_valid = 1'b0;
      if (pend_cnt != 0) begin
        pend_cnt--;
        if (pend_cnt == 0) begin
          rsp_valid = 1'b1;
          rsp_data  = pend_data;
        end
      end
      stall_q++;
      cmd_ready = (stall_q % 3) != 0;
      if (cmd_valid && cmd_ready) begin
        if (log_n < 16) log_q[log_n] = {cmd_read, cmd_oe, cmd_cnt_m1, cmd_wdata};
        log_n++;
        if (cmd_read) begin
          pend_cnt  = 2;
          pend_data = resp_for(rd_idx);
          rd_idx++;
        end
      end
    end
  end

  task automatic add_exp(input bit rd, input bit oe, input int m1,
                         input logic [32:0] d, input string tag);
    exp_q[exp_n]   = {rd, oe, CNT_W'(m1), d};
    exp_tag[exp_n] = tag;
    exp_n++;
  endtask

  task automatic build_exp(input logic [58:0] v);
    logic [7:0] rb;
    int tm1, rem, n;
    tm1 = int'(v[54:53]);
    rb = 8'h81;
    rb[1] = v[58];
    rb[2] = v[57];
    rb[3] = v[55];
    rb[4] = v[56];
    rb[5] = ($countones({v[58], v[57], v[56:55]}) % 2) == 1;
    exp_n = 0;
    add_exp(1'b0, 1'b1, 7, 33'(rb), "R1");
    add_exp(1'b1, 1'b0, tm1 + 3, '0, "R2");
    if (v[51:49] == 3'd1) begin
      if (v[57]) begin
        add_exp(1'b1, 1'b0, 32, '0, "R3");
        add_exp(1'b0, 1'b0, tm1, '0, "R3");
      end else begin
        add_exp(1'b0, 1'b0, tm1, '0, "R4");
        add_exp(1'b0, 1'b1, 32, {^v[31:0], v[31:0]}, "R4");
      end
      rem = int'(v[47:32]);
      while (rem > 0) begin
        n = (rem > 256) ? 256 : rem;
        add_exp(1'b0, 1'b1, n - 1, '0, "R5");
        rem -= n;
      end
    end else if (v[51:49] == 3'd2 || v[51:49] == 3'd4) begin
      if (v[52] && v[57]) add_exp(1'b1, 1'b0, 32, '0, "R6");
      add_exp(1'b0, 1'b0, tm1, '0, "R6");
      if (v[52] && !v[57]) add_exp(1'b0, 1'b1, 31, '0, "R6");
    end else begin
      add_exp(1'b1, 1'b0, tm1 + 33, '0, "R7");
    end
  endtask

  task automatic run_xfer(input logic [58:0] v, input bit inject);
    bit ok_r, ok_p;
    build_exp(v);
    @(negedge clk);
    cur = v; rd_idx = 0; log_n = 0;
    req_apndp = v[58]; req_rnw = v[57]; req_addr = v[56:55]; turn_m1 = v[54:53];
    data_phase = v[52]; idle_cycles = v[47:32]; wdata = v[31:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (inject) begin
      repeat (4) @(negedge clk);
      req_rnw = ~v[57]; req_addr = ~v[56:55]; idle_cycles = '0;
      start = 1'b1;  // R8: must be ignored while busy
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    ok_r = (v[51:49] == 3'd1) && v[57];
    ok_p = ok_r && v[48];
    chk(ack == v[51:49], "R2", 64'(ack), 64'(v[51:49]));
    chk(rdata == (ok_r ? v[31:0] : 32'd0), "R3", 64'(rdata), ok_r ? 64'(v[31:0]) : 64'd0);
    chk(parity_err == ok_p, "R10", 64'(parity_err), 64'(ok_p));
    chk(log_n == exp_n, "R8", 64'(log_n), 64'(exp_n));
    for (int i = 0; i < exp_n && i < log_n; i++)
      chk(log_q[i] == exp_q[i], exp_tag[i], 64'(log_q[i]), 64'(exp_q[i]));
    @(negedge clk);
    chk(!done && !busy, "R8", {62'd0, done, busy}, 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; req_apndp = 1'b0; req_rnw = 1'b0; req_addr = '0;
    turn_m1 = '0; data_phase = 1'b0; idle_cycles = '0; wdata = '0; cur = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state
    chk(!busy && !done && !cmd_valid, "R8",
        {61'd0, busy, done, cmd_valid}, 64'd0);
    chk(ack == 3'd0 && rdata == 32'd0 && !parity_err, "R10",
        {28'd0, ack, parity_err, rdata}, 64'd0);

    for (int v = 0; v < NV; v++) run_xfer(VECS[v], 1'b0);

    // Second start during a long write transfer must be ignored.
    run_xfer(VECS[2], 1'b1);
    // Back-to-back after ignored start: a read with parity error again.
    run_xfer(VECS[1], 1'b0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule